// File: doc/BRIEF.md
# Micro-op Integer ALU with Lane Merge

This unit executes one register micro-op per cycle for an integer pipeline. Each request carries the old value of the destination, two source words, an 8-bit immediate, the current condition-flag word, an operand size of 1, 2, 4 or 8 bytes, an opcode, a condition code and a flag-update mask. The unit computes add, add-with-carry, subtract, subtract-with-borrow, AND, OR, XOR, low multiply or conditional move on the operand-size lane. It writes the result into only that lane of the old destination and updates only the flag bits that the mask enables.

The result and the new flag word are registered. They appear with an output-valid pulse one clock after the input strobe, and they hold while no strobe arrives. Decode, the register file and shifts sit outside the block.

Top module: `uop_alu`

## Requirements
- R1: One cycle after a clock edge that samples `in_valid` high, `out_valid` is 1 and `dst_new`/`flags_out` carry that request's results. After an edge that samples `in_valid` low, `out_valid` is 0 and both outputs keep their previous values.
- R2: `size` selects the lane: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Bytes of the destination above the lane keep their old value.
- R3: With `use_imm` = 1 the second operand is `imm` zero-extended to 64 bits, and `src_b` is ignored. With `use_imm` = 0 the second operand is `src_b`.
- R4: Opcode 0 (add) gives `src_a + op2`. Opcode 1 (add-with-carry) also adds flag bit 0 (carry).
- R5: Opcode 2 (subtract) gives `src_a - op2`. Opcode 3 (subtract-with-borrow) also subtracts flag bit 0. For both, the carry flag is the borrow out of the lane's top bit.
- R6: Opcodes 4, 5 and 6 are AND, OR and XOR. For these, the carry (bit 0) and overflow (bit 4) flags become 0 where the mask enables them.
- R7: Opcode 7 multiplies the old destination by the second operand and keeps the low lane bytes. Its carry and overflow flags are 0 where enabled.
- R8: `flags_out` bit i changes only when `fmask` bit i is 1. With a mask of zero the flag word passes through unchanged.
- R9: The flag layout is bit 0 carry, bit 1 parity (1 when the lane result has an even number of ones), bit 2 zero, bit 3 sign (the lane's top bit) and bit 4 signed overflow. For add and subtract, carry and overflow come from the lane's top bit.
- R10: Opcode 8 (conditional move) tests the current flags. `cond[3:1]` selects always, C, Z, S, V, P, C|Z or S!=V, and `cond[0]` inverts the test. When the test holds, the result is `src_a` with its lane replaced by the second operand. Otherwise the old destination is kept. The move never changes the flags.
- R11: While `rst` is high, `out_valid`, `dst_new` and `flags_out` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Opcode (0..8) |
| size | input | 2 | Operand size code |
| use_imm | input | 1 | Take the second operand from the immediate |
| cond | input | 4 | Condition code for the conditional move |
| fmask | input | 5 | Flag-update enables |
| flags_in | input | 5 | Current flag word |
| dst_old | input | 64 | Old destination value |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source (register form) |
| imm | input | 8 | Immediate |
| out_valid | output | 1 | Result strobe |
| dst_new | output | 64 | Merged destination value |
| flags_out | output | 5 | Updated flag word |

## Verification
A single request can both consume the carry flag and produce it. Add-with-carry and subtract-with-borrow read carry as an input and can rewrite it through the mask. A conditional move reads the flags as its condition in the same cycle that it merges a lane into a different base word. The bench provokes both cases by pairing carry-in values with full, partial and empty masks, and by running moves whose condition is true and false on narrow lanes. A behavioural model judges each result on the following clock, computing borrow and signed overflow by comparison rather than by carry chains.

// File: rtl/uop_alu_pkg.sv
package uop_alu_pkg;

    localparam int DATA_W   = 64;
    localparam int IMM_W    = 8;
    localparam int FLAG_W   = 5;
    localparam int OP_W     = 4;
    localparam int SIZE_W   = 2;
    localparam int COND_W   = 4;
    localparam int LANE_IDX_W = $clog2(DATA_W);
    localparam int WIDE_IDX_W = LANE_IDX_W + 1;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_MUL = 4'd7,
        OP_MOV = 4'd8
    } uop_op_e;

    typedef enum logic [2:0] {
        CT_ALWAYS = 3'd0,
        CT_CRY    = 3'd1,
        CT_ZRO    = 3'd2,
        CT_SGN    = 3'd3,
        CT_OVF    = 3'd4,
        CT_PAR    = 3'd5,
        CT_BELOW_EQ = 3'd6,
        CT_LESS   = 3'd7
    } cond_test_e;

    // Flag word: carry in bit 0 up to overflow in bit 4.
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic cry;
    } flags_t;

    typedef struct packed {
        logic cry;
        logic ovf;
    } arith_flags_t;

    function automatic word_t lane_mask(input logic [SIZE_W-1:0] sz);
        logic [LANE_IDX_W:0] bits;
        bits = WIDE_IDX_W'(8) << sz;
        return ~({DATA_W{1'b1}} << bits);
    endfunction

    function automatic logic [LANE_IDX_W-1:0] lane_msb(input logic [SIZE_W-1:0] sz);
        logic [LANE_IDX_W:0] bits;
        bits = WIDE_IDX_W'(8) << sz;
        return LANE_IDX_W'(bits - 1'b1);
    endfunction

    function automatic logic cond_holds(input logic [COND_W-1:0] cc, input flags_t f);
        logic t;
        case (cond_test_e'(cc[COND_W-1:1]))
            CT_ALWAYS:   t = 1'b1;
            CT_CRY:      t = f.cry;
            CT_ZRO:      t = f.zro;
            CT_SGN:      t = f.sgn;
            CT_OVF:      t = f.ovf;
            CT_PAR:      t = f.par;
            CT_BELOW_EQ: t = f.cry | f.zro;
            default:     t = f.sgn ^ f.ovf;
        endcase
        return t ^ cc[0];
    endfunction

    function automatic logic is_arith(input uop_op_e o);
        return (o == OP_ADD) || (o == OP_ADC) || (o == OP_SUB) || (o == OP_SBB);
    endfunction

    function automatic logic is_known(input uop_op_e o);
        return o inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_OR, OP_XOR, OP_MUL, OP_MOV};
    endfunction

endpackage

// File: rtl/uop_operand_sel.sv
module uop_operand_sel
    import uop_alu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int IMM_BITS = IMM_W
) (
    input  logic [SIZE_W-1:0]     size,
    input  logic                  use_imm,
    input  logic [W-1:0]          src_b,
    input  logic [IMM_BITS-1:0]   imm,
    output logic [W-1:0]          op2,
    output logic [W-1:0]          lmask,
    output logic [LANE_IDX_W-1:0] msb
);
    localparam int PAD_W = W - IMM_BITS;

    always_comb begin
        op2   = use_imm ? {{PAD_W{1'b0}}, imm} : src_b;
        lmask = lane_mask(size);
        msb   = lane_msb(size);
    end
endmodule

// File: rtl/uop_adder.sv
module uop_adder
    import uop_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]          a,
    input  logic [W-1:0]          b,
    input  logic [W-1:0]          lmask,
    input  logic [LANE_IDX_W-1:0] msb,
    input  logic                  subtract,
    input  logic                  cin,
    output logic [W-1:0]          sum,
    output arith_flags_t          aflags
);
    localparam int SUM_W = W + 1;

    logic [W-1:0]          a_m;
    logic [W-1:0]          b_m;
    logic [SUM_W-1:0]      wide;
    logic [WIDE_IDX_W-1:0] out_idx;
    logic                  c_out;
    logic                  c_into_top;

    always_comb begin
        a_m        = a & lmask;
        b_m        = (subtract ? ~b : b) & lmask;
        wide       = {1'b0, a_m} + {1'b0, b_m} + {{W{1'b0}}, cin};
        sum        = wide[W-1:0];
        out_idx    = {1'b0, msb} + 1'b1;
        c_out      = wide[out_idx];
        c_into_top = wide[msb] ^ a_m[msb] ^ b_m[msb];
        aflags.cry = subtract ? ~c_out : c_out;
        aflags.ovf = c_out ^ c_into_top;
    end
endmodule

// File: rtl/uop_flag_gen.sv
module uop_flag_gen
    import uop_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]          res,
    input  logic [W-1:0]          lmask,
    input  logic [LANE_IDX_W-1:0] msb,
    input  arith_flags_t          aflags,
    input  logic                  from_adder,
    input  logic                  update,
    input  flags_t                flags_in,
    input  logic [FLAG_W-1:0]     fmask,
    output flags_t                flags_new
);
    logic [W-1:0] lane;
    flags_t       gen;

    always_comb begin
        lane    = res & lmask;
        gen.zro = ~|lane;
        gen.sgn = res[msb];
        gen.par = ~^lane;
        // Non-adder ops may only clear carry and overflow.
        gen.cry = from_adder & aflags.cry;
        gen.ovf = from_adder & aflags.ovf;
        if (update)
            flags_new = flags_t'((flags_in & ~fmask) | (gen & fmask));
        else
            flags_new = flags_in;
    end
endmodule

// File: rtl/uop_alu.sv
module uop_alu
    import uop_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic [SIZE_W-1:0]   size,
    input  logic                use_imm,
    input  logic [COND_W-1:0]   cond,
    input  logic [FLAG_W-1:0]   fmask,
    input  logic [FLAG_W-1:0]   flags_in,
    input  logic [DATA_W-1:0]   dst_old,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [IMM_W-1:0]    imm,
    output logic                out_valid,
    output logic [DATA_W-1:0]   dst_new,
    output logic [FLAG_W-1:0]   flags_out
);
    uop_op_e               op_e;
    flags_t                cur_flags;
    word_t                 op2;
    word_t                 lmask;
    logic [LANE_IDX_W-1:0] msb;
    logic                  subtract;
    logic                  carry_in;
    word_t                 sum;
    arith_flags_t          aflags;
    word_t                 raw;
    word_t                 base;
    logic                  write_en;
    word_t                 merged;
    flags_t                flags_next;

    assign op_e      = uop_op_e'(op);
    assign cur_flags = flags_t'(flags_in);

    uop_operand_sel #(.W(DATA_W), .IMM_BITS(IMM_W)) u_sel (
        .size    (size),
        .use_imm (use_imm),
        .src_b   (src_b),
        .imm     (imm),
        .op2     (op2),
        .lmask   (lmask),
        .msb     (msb)
    );

    always_comb begin
        subtract = (op_e == OP_SUB) || (op_e == OP_SBB);
        case (op_e)
            OP_ADC:  carry_in = cur_flags.cry;
            OP_SUB:  carry_in = 1'b1;
            OP_SBB:  carry_in = ~cur_flags.cry;
            default: carry_in = 1'b0;
        endcase
    end

    uop_adder #(.W(DATA_W)) u_add (
        .a        (src_a),
        .b        (op2),
        .lmask    (lmask),
        .msb      (msb),
        .subtract (subtract),
        .cin      (carry_in),
        .sum      (sum),
        .aflags   (aflags)
    );

    always_comb begin
        case (op_e)
            OP_ADD, OP_ADC,
            OP_SUB, OP_SBB: raw = sum;
            OP_AND:         raw = src_a & op2;
            OP_OR:          raw = src_a | op2;
            OP_XOR:         raw = src_a ^ op2;
            OP_MUL:         raw = dst_old * op2;
            OP_MOV:         raw = op2;
            default:        raw = dst_old;
        endcase
        base     = (op_e == OP_MOV) ? src_a : dst_old;
        write_en = is_known(op_e) &&
                   ((op_e != OP_MOV) || cond_holds(cond, cur_flags));
        merged   = write_en ? ((base & ~lmask) | (raw & lmask)) : dst_old;
    end

    uop_flag_gen #(.W(DATA_W)) u_flg (
        .res        (raw),
        .lmask      (lmask),
        .msb        (msb),
        .aflags     (aflags),
        .from_adder (is_arith(op_e)),
        .update     (is_known(op_e) && (op_e != OP_MOV)),
        .flags_in   (cur_flags),
        .fmask      (fmask),
        .flags_new  (flags_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst_new   <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_new   <= merged;
                flags_out <= flags_next;
            end
        end
    end
endmodule

// File: rtl/uop_alu_chk.sv
module uop_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic [1:0]  size,
    input logic [3:0]  cond,
    input logic [4:0]  fmask,
    input logic [4:0]  flags_in,
    input logic [63:0] dst_old,
    input logic        out_valid,
    input logic [63:0] dst_new,
    input logic [4:0]  flags_out
);
    // R1
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(dst_new) && $stable(flags_out)));

    // R2
    byte_lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size == 2'd0 && op != 4'd8) |=> (dst_new[63:8] == $past(dst_old[63:8])));

    // R8
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmask == 5'd0) |=> (flags_out == $past(flags_in)));

    // R6
    logic_carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'd4 || op == 4'd5 || op == 4'd6) && fmask[0]) |=> !flags_out[0]);

    // R6
    logic_ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'd4 || op == 4'd5 || op == 4'd6) && fmask[4]) |=> !flags_out[4]);

    // R10
    move_never_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd8 && cond == 4'd1) |=> (dst_new == $past(dst_old)));

    // R10
    move_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd8) |=> (flags_out == $past(flags_in)));
endmodule

bind uop_alu uop_alu_chk u_chk (.*);

// File: tb/uop_alu_bench.sv
module uop_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  size = '0;
    logic        use_imm = 1'b0;
    logic [3:0]  cond = '0;
    logic [4:0]  fmask = '0;
    logic [4:0]  flags_in = '0;
    logic [63:0] dst_old = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [7:0]  imm = '0;
    logic        out_valid;
    logic [63:0] dst_new;
    logic [4:0]  flags_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic        exp_v = 1'b0;
    logic [63:0] exp_d = '0;
    logic [4:0]  exp_f = '0;
    string       tag_d = "R1";
    string       tag_f = "R1";

    always #4 clk = ~clk;

    uop_alu u_uop_alu (.*);

    function automatic void ref_model(
        input logic [3:0] o, input logic [1:0] sz, input logic ui,
        input logic [3:0] cc, input logic [4:0] fm, input logic [4:0] fi,
        input logic [63:0] d, input logic [63:0] a, input logic [63:0] bsrc,
        input logic [7:0] im, output logic [63:0] rd, output logic [4:0] rf);
        int w;
        logic [63:0] m, b, r;
        logic [64:0] wide;
        logic c, v, sa, sb, sr, take, z, s, p, bi;
        w = 8 << sz;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        b = ui ? {56'd0, im} : bsrc;
        c = 0; v = 0; r = d;
        sa = a[w-1]; sb = b[w-1];
        if (o == 4'd8) begin
            case (cc[3:1])
                3'd0: take = 1;
                3'd1: take = fi[0];
                3'd2: take = fi[2];
                3'd3: take = fi[3];
                3'd4: take = fi[4];
                3'd5: take = fi[1];
                3'd6: take = fi[0] | fi[2];
                default: take = fi[3] != fi[4];
            endcase
            take = take ^ cc[0];
            rd = take ? ((a & ~m) | (b & m)) : d;
            rf = fi;
            return;
        end
        case (o)
            4'd0, 4'd1: begin
                wide = {1'b0, a & m} + {1'b0, b & m} + ((o == 4'd1) ? 65'(fi[0]) : 65'd0);
                r = wide[63:0];
                c = wide[w];
                sr = r[w-1];
                v = (sa == sb) && (sr != sa);
            end
            4'd2, 4'd3: begin
                bi = (o == 4'd3) ? fi[0] : 1'b0;
                r = a - b - 64'(bi);
                c = ({1'b0, a & m} < ({1'b0, b & m} + 65'(bi)));
                sr = r[w-1];
                v = (sa != sb) && (sr != sa);
            end
            4'd4: r = a & b;
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            default: r = d * b;
        endcase
        z = ((r & m) == 64'd0);
        s = r[w-1];
        p = ($countones(r & m) % 2) == 0;
        rf = (fi & ~fm) | ({v, s, z, p, c} & fm);
        rd = (d & ~m) | (r & m);
    endfunction

    function automatic string op_tag(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R4";
            4'd2, 4'd3: return "R5";
            4'd4, 4'd5, 4'd6: return "R6";
            4'd7: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic compare_outputs();
        checks++;
        if (out_valid !== exp_v) begin
            errors++;
            $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, exp_v);
        end
        checks++;
        if (dst_new !== exp_d) begin
            errors++;
            $display("FAIL %s dst_new actual=%h expected=%h", exp_v ? tag_d : "R1", dst_new, exp_d);
        end
        checks++;
        if (flags_out !== exp_f) begin
            errors++;
            $display("FAIL %s flags_out actual=%b expected=%b", exp_v ? tag_f : "R1", flags_out, exp_f);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] o, input logic [1:0] sz,
                        input logic ui, input logic [3:0] cc, input logic [4:0] fm,
                        input logic [4:0] fi, input logic [63:0] d, input logic [63:0] a,
                        input logic [63:0] b, input logic [7:0] im);
        logic [63:0] rd;
        logic [4:0]  rf;
        @(negedge clk);
        compare_outputs();
        in_valid = v; op = o; size = sz; use_imm = ui; cond = cc; fmask = fm;
        flags_in = fi; dst_old = d; src_a = a; src_b = b; imm = im;
        exp_v = v;
        if (v) begin
            ref_model(o, sz, ui, cc, fm, fi, d, a, b, im, rd, rf);
            exp_d = rd;
            exp_f = rf;
            tag_d = op_tag(o);
            if (ui) tag_d = {tag_d, "/R3"};
            if (sz != 2'd3) tag_d = {tag_d, "/R2"};
            if (o == 4'd8) tag_f = "R10";
            else if (fm != 5'h1F) tag_f = "R8";
            else tag_f = {op_tag(o), "/R9"};
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        compare_outputs();
        rst = 1'b0;
        // R4/R9: byte add with signed overflow, upper bytes kept
        step(1, 4'd0, 2'd0, 0, 4'd0, 5'h1F, 5'd0, 64'hAAAA_BBBB_CCCC_DDEE, 64'h7F, 64'h01, 8'd0);
        // R4: byte add producing carry and zero
        step(1, 4'd0, 2'd0, 0, 4'd0, 5'h1F, 5'd0, 64'h1234_5678_9ABC_DEF0, 64'hFF, 64'h01, 8'd0);
        // R4: add-with-carry, carry read and rewritten in one op
        step(1, 4'd1, 2'd1, 0, 4'd0, 5'h1F, 5'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFE, 64'h0001, 8'd0);
        // R5: word subtract with borrow out
        step(1, 4'd2, 2'd1, 0, 4'd0, 5'h1F, 5'd0, 64'h5555_5555_5555_5555, 64'h0003, 64'h0005, 8'd0);
        // R5: subtract-with-borrow on 32-bit lane
        step(1, 4'd3, 2'd2, 0, 4'd0, 5'h1F, 5'h01, 64'h0, 64'h8000_0000, 64'h0000_0000, 8'd0);
        // R6: AND clears incoming carry and overflow
        step(1, 4'd4, 2'd3, 0, 4'd0, 5'h1F, 5'h11, 64'h0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 8'd0);
        // R8: OR with empty mask leaves flags
        step(1, 4'd5, 2'd2, 0, 4'd0, 5'h00, 5'h1A, 64'hDEAD_BEEF_0000_0000, 64'h1, 64'h2, 8'd0);
        // R3: XOR with immediate, src_b ignored
        step(1, 4'd6, 2'd0, 1, 4'd0, 5'h1F, 5'd0, 64'h0, 64'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 8'hF0);
        // R1: idle cycle holds outputs
        step(0, 4'd0, 2'd0, 0, 4'd0, 5'h1F, 5'd0, 64'h0, 64'h0, 64'h0, 8'd0);
        // R7: 32-bit low multiply of old destination
        step(1, 4'd7, 2'd2, 0, 4'd0, 5'h1F, 5'h11, 64'hCAFE_0000_0001_0003, 64'h0, 64'h0000_0000_8000_0001, 8'd0);
        // R10: move with condition true (Z set, test Z)
        step(1, 4'd8, 2'd1, 0, 4'd4, 5'h1F, 5'h04, 64'h1111, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1234, 8'd0);
        // R10: move with condition false (never)
        step(1, 4'd8, 2'd1, 0, 4'd1, 5'h1F, 5'h04, 64'h1111, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1234, 8'd0);
        // R10: move with immediate on S!=V
        step(1, 4'd8, 2'd0, 1, 4'd14, 5'h00, 5'h08, 64'h0, 64'h7777_7777_7777_7777, 64'h0, 8'h5A);
        // R8: partial mask updates only zero flag
        step(1, 4'd2, 2'd3, 0, 4'd0, 5'h04, 5'h1B, 64'h0, 64'h42, 64'h42, 8'd0);
        // R4/R5 mix: back-to-back pseudo-random requests with idle gaps
        for (int i = 0; i < 400; i++) begin
            step(($urandom_range(0, 5) != 0), 4'($urandom_range(0, 8)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 4'($urandom), 5'($urandom), 5'($urandom),
                 {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom));
        end
        step(0, 4'd0, 2'd0, 0, 4'd0, 5'h0, 5'd0, 64'h0, 64'h0, 64'h0, 8'd0);
        @(negedge clk);
        compare_outputs();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule